// File: doc/BRIEF.md
# Rule-Count Category Classifier

This block picks a winning category from a set of rule activation bits. There are NUM_CAT categories, and each one owns NUM_RULES rule bits. All categories receive their bits at the same moment on one shared wide input. For each category, the block counts the rules that are active. A maximum search over those counts then yields the index of the best category and its count.

A single-cycle `start` pulse samples the input and launches one classification. Three cycles later, `done` pulses high for one cycle. `winIdx` and `winScore` are updated at that point and keep their values until the next result.

A downstream consumer can form a certainty ratio by dividing `winScore` by the constant `maxScore`, which always equals NUM_RULES. The block itself contains no divider.

Top module: `rule_count_classifier`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` is 0 and `winIdx` and `winScore` are both 0.
- R2: The score of category c is the number of 1 bits in `ruleBits[c*NUM_RULES +: NUM_RULES]`, and `winScore` reports the winning category's score.
- R3: `winIdx` is the index of the category with the highest score.
- R4: When several categories share the highest score, `winIdx` is the lowest of their indices. An all-zero input gives index 0 and score 0.
- R5: Suppose `start` is sampled high at clock edge E while the block is idle. Then `done` is 1 for exactly the one cycle that follows edge E+2. This is well within 10 cycles.
- R6: `ruleBits` is sampled only at the start edge, so later changes to it have no effect on that result.
- R7: A `start` pulse that arrives while a classification is in flight is ignored. It produces no second `done` and does not change the result.
- R8: `maxScore` always equals NUM_RULES (8 by default), in a field $clog2(NUM_RULES+1) bits wide.
- R9: Between `done` pulses, `winIdx` and `winScore` stay unchanged, whatever happens on `ruleBits` and `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch one classification; ignored while busy |
| ruleBits | input | NUM_CAT*NUM_RULES | Rule activation bits; category c occupies bits c*NUM_RULES upward |
| done | output | 1 | One-cycle pulse marking a new result |
| winIdx | output | IDX_W (6) | Winning category index |
| winScore | output | SCORE_W (4) | Active-rule count of the winning category |
| maxScore | output | SCORE_W (4) | Constant NUM_RULES, the largest possible score |

## Verification
Two of the block's behaviours can fall in the same cycle.

The first pair is a new `start` arriving, and `ruleBits` changing, while the counting stage is still consuming an earlier sample. The bench provokes this by pulsing `start` with a different pattern in the cycle after a launch. It also changes `ruleBits` right after the sampling edge. The bench then judges the result against the first pattern only and confirms that no extra `done` appears.

The second pair is ties and the maximum search meeting in one evaluation. Patterns are built in which several categories reach the same top count, including the full count NUM_RULES. The bench expects the lowest of those indices.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  // Strobes from control to datapath, one per pipeline step
  typedef struct packed {
    logic capture;  // sample the rule bits
    logic count;    // load per-category counts
    logic pick;     // load the winner registers
  } rccStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_PICK  = 2'd2
  } rccState_t;
endpackage

// File: rtl/rcc_popcount.sv
module rcc_popcount #(
  parameter int NUM_RULES = 8,
  localparam int SCORE_W = $clog2(NUM_RULES + 1)
) (
  input  logic [NUM_RULES-1:0] bits,
  output logic [SCORE_W-1:0]   count
);
  always_comb begin
    count = '0;
    for (int r = 0; r < NUM_RULES; r++) begin
      count = count + SCORE_W'(bits[r]);
    end
  end
endmodule

// File: rtl/rcc_control.sv
module rcc_control
  import rcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output rccStrobes_t strobes,
  output logic        done
);
  rccState_t state;

  always_comb begin
    strobes.capture = (state == ST_IDLE) && start;
    strobes.count   = (state == ST_COUNT);
    strobes.pick    = (state == ST_PICK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strobes.pick;
      unique case (state)
        ST_IDLE:  if (start) state <= ST_COUNT;
        ST_COUNT: state <= ST_PICK;
        ST_PICK:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rcc_datapath.sv
module rcc_datapath
  import rcc_pkg::*;
#(
  parameter int NUM_CAT   = 40,
  parameter int NUM_RULES = 8,
  parameter int IDX_W     = 6,
  localparam int SCORE_W  = $clog2(NUM_RULES + 1),
  localparam int IN_W     = NUM_CAT * NUM_RULES
) (
  input  logic               clk,
  input  logic               rstN,
  input  rccStrobes_t        strobes,
  input  logic [IN_W-1:0]    ruleBits,
  output logic [IDX_W-1:0]   winIdx,
  output logic [SCORE_W-1:0] winScore
);
  logic [IN_W-1:0]    ruleReg;
  logic [SCORE_W-1:0] countNext [NUM_CAT];
  logic [SCORE_W-1:0] scoreReg  [NUM_CAT];
  logic [IDX_W-1:0]   bestIdx;
  logic [SCORE_W-1:0] bestScore;

  always_ff @(posedge clk) begin
    if (!rstN) ruleReg <= '0;
    else if (strobes.capture) ruleReg <= ruleBits;
  end

  for (genvar c = 0; c < NUM_CAT; c++) begin : gCat
    rcc_popcount #(.NUM_RULES(NUM_RULES)) uCount (
      .bits  (ruleReg[c*NUM_RULES +: NUM_RULES]),
      .count (countNext[c])
    );
    always_ff @(posedge clk) begin
      if (!rstN) scoreReg[c] <= '0;
      else if (strobes.count) scoreReg[c] <= countNext[c];
    end
  end

  // Strict greater-than keeps the lowest index on ties
  always_comb begin
    bestIdx   = '0;
    bestScore = scoreReg[0];
    for (int i = 1; i < NUM_CAT; i++) begin
      if (scoreReg[i] > bestScore) begin
        bestIdx   = IDX_W'(i);
        bestScore = scoreReg[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winIdx   <= '0;
      winScore <= '0;
    end else if (strobes.pick) begin
      winIdx   <= bestIdx;
      winScore <= bestScore;
    end
  end
endmodule

// File: rtl/rule_count_classifier.sv
module rule_count_classifier
  import rcc_pkg::*;
#(
  parameter int NUM_CAT   = 40,
  parameter int NUM_RULES = 8,
  parameter int IDX_W     = 6,
  localparam int SCORE_W  = $clog2(NUM_RULES + 1),
  localparam int IN_W     = NUM_CAT * NUM_RULES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [IN_W-1:0]    ruleBits,
  output logic               done,
  output logic [IDX_W-1:0]   winIdx,
  output logic [SCORE_W-1:0] winScore,
  output logic [SCORE_W-1:0] maxScore
);
  rccStrobes_t strobes;

  assign maxScore = SCORE_W'(NUM_RULES);

  rcc_control uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  rcc_datapath #(
    .NUM_CAT   (NUM_CAT),
    .NUM_RULES (NUM_RULES),
    .IDX_W     (IDX_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .ruleBits (ruleBits),
    .winIdx   (winIdx),
    .winScore (winScore)
  );
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
  parameter int NUM_CAT   = 40,
  parameter int NUM_RULES = 8,
  parameter int IDX_W     = 6,
  localparam int SCORE_W  = $clog2(NUM_RULES + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               done,
  input logic [IDX_W-1:0]   winIdx,
  input logic [SCORE_W-1:0] winScore,
  input logic [SCORE_W-1:0] maxScore
);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start, 3));

  // R9
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(winIdx));

  // R9
  score_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(winScore));

  // R2
  score_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (winScore <= maxScore));

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(winIdx) < NUM_CAT));
endmodule

bind rule_count_classifier rcc_checker #(
  .NUM_CAT   (NUM_CAT),
  .NUM_RULES (NUM_RULES),
  .IDX_W     (IDX_W)
) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .done     (done),
  .winIdx   (winIdx),
  .winScore (winScore),
  .maxScore (maxScore)
);

// File: tb/sim_rule_count_classifier.sv
module sim_rule_count_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int NCAT  = 40;
  localparam int NRULE = 8;
  localparam int IW    = 6;
  localparam int SW    = $clog2(NRULE + 1);
  localparam int INW   = NCAT * NRULE;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [INW-1:0] ruleBits = '0;
  logic           done;
  logic [IW-1:0]  winIdx;
  logic [SW-1:0]  winScore;
  logic [SW-1:0]  maxScore;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rule_count_classifier #(.NUM_CAT(NCAT), .NUM_RULES(NRULE), .IDX_W(IW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .ruleBits(ruleBits),
    .done(done), .winIdx(winIdx), .winScore(winScore), .maxScore(maxScore)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Set category cat to have n active rules (lowest n bits)
  function automatic logic [INW-1:0] withCat(input logic [INW-1:0] v,
                                              input int cat, input int n);
    logic [INW-1:0] r = v;
    for (int b = 0; b < NRULE; b++) r[cat*NRULE + b] = (b < n);
    return r;
  endfunction

  // Launch at a negedge; done must show at the third negedge only
  task automatic classify(input logic [INW-1:0] pat, input string req,
                          input int expIdx, input int expScore);
    ruleBits = pat;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({req, " R5 done low n1"}, int'(done), 0);
    @(negedge clk);
    check({req, " R5 done low n2"}, int'(done), 0);
    @(negedge clk);
    check({req, " R5 done high"}, int'(done), 1);
    check({req, " idx"}, int'(winIdx), expIdx);
    check({req, " R2 score"}, int'(winScore), expScore);
    @(negedge clk);
    check({req, " R5 done single"}, int'(done), 0);
  endtask

  task automatic testReset();
    check("R1 done", int'(done), 0);
    check("R1 idx", int'(winIdx), 0);
    check("R1 score", int'(winScore), 0);
    check("R8 maxScore", int'(maxScore), NRULE);
  endtask

  task automatic testSingleWinner();
    logic [INW-1:0] p = '0;
    p = withCat(p, 2, 3);
    p = withCat(p, 17, 5);
    p = withCat(p, 33, 4);
    classify(p, "R3 single", 17, 5);
  endtask

  task automatic testTie();
    logic [INW-1:0] p = '0;
    p = withCat(p, 30, 6);
    p = withCat(p, 3, 6);
    p = withCat(p, 10, 2);
    classify(p, "R4 tie", 3, 6);
  endtask

  task automatic testZeros();
    classify('0, "R4 zeros", 0, 0);
  endtask

  task automatic testFullLast();
    logic [INW-1:0] p = '0;
    p = withCat(p, 39, NRULE);
    p = withCat(p, 0, NRULE - 1);
    classify(p, "R2 full last", 39, NRULE);
    check("R8 maxScore after", int'(maxScore), NRULE);
  endtask

  task automatic testRamp();
    logic [INW-1:0] p = '0;
    for (int c = 0; c < NCAT; c++) p = withCat(p, c, c % (NRULE + 1));
    classify(p, "R4 ramp", NRULE, NRULE);
  endtask

  // Rule bits change and a second start arrive after the sampling edge
  task automatic testSampleAndBusy();
    logic [INW-1:0] p = '0;
    logic [INW-1:0] q = '0;
    p = withCat(p, 12, 7);
    q = withCat(q, 25, NRULE);
    ruleBits = p;
    start = 1'b1;
    @(negedge clk);
    ruleBits = q;   // R6: must not affect this result
    start = 1'b1;   // R7: ignored while busy
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check("R6/R7 done", int'(done), 1);
    check("R6 idx", int'(winIdx), 12);
    check("R6 score", int'(winScore), 7);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R7 no extra done", int'(done), 0);
    end
    check("R7 idx kept", int'(winIdx), 12);
  endtask

  task automatic testHold();
    logic [INW-1:0] p = '0;
    p = withCat(p, 21, 4);
    classify(p, "R3 hold setup", 21, 4);
    ruleBits = withCat('0, 5, NRULE);
    for (int k = 0; k < 5; k++) @(negedge clk);
    check("R9 idx held", int'(winIdx), 21);
    check("R9 score held", int'(winScore), 4);
    check("R9 no done", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingleWinner();
    testTie();
    testZeros();
    testFullLast();
    testRamp();
    testSampleAndBusy();
    testHold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule